// File: doc/BRIEF.md
# Serial NOVRAM Command Interface

This block is the serial slave front end of a small nonvolatile shadow memory. It watches three host pins: an active-low select, a serial clock and a serial data input. All three are brought into the system clock domain, and the block acts on the clock edges it finds in the synchronized samples. A frame starts with a 1 bit. The 8-bit instruction behind it selects one of seven operations. Five of these operations are pure commands, and each one leaves the block as a single-cycle strobe to a separate nonvolatile controller. The other two operations are a RAM word write and a RAM word read on a 16-word by 16-bit array that this block holds.

The nonvolatile controller returns two signals. The write-permit level reports the state of its write-enable latch. The busy level blocks all decoding while a store or recall is in progress. The serial output has a driven value and an enable. The enable is high only while read data is being shifted out.

The serial pins have no flow control, so the block has no valid/ready port and applies no back-pressure. The host sets the pace with its clock. Each half period of the serial clock must last at least three system clocks so that every edge is seen.

Top module: `nvsram_serial_if`

## Requirements
- R1: While select is low and no frame has started, bits of value 0 sampled on rising serial-clock edges are ignored. The first 1 becomes the most significant bit of the instruction.
- R2: The instruction is 8 bits, sent most significant first and sampled on rising edges. Bits 6..3 hold a word address and bits 2..0 hold the operation code. Each code has its own single strobe: 000 clears write enable (`cmd_we_clr`), 001 stores (`cmd_store`), 010 enables autostore (`cmd_autostore_en`), 100 sets write enable (`cmd_we_set`) and 101 recalls (`cmd_recall`).
- R3: Every command raises its strobe for exactly one system clock, and at most one strobe is high at any time.
- R4: Codes 11x read the addressed word. The code is recognised after the seventh instruction bit. Bit D0 is driven after the next falling serial-clock edge, and each later falling edge moves to the next bit. After D15 the output wraps back to D0.
- R5: `spi_sdo_en` is low except while read data is being shifted. Raising select drops it and resets framing. After a command has been decoded, further bits in the same frame have no effect.
- R6: Code 011 writes. The data bits that follow the instruction are placed D0 first, and the word is written to the addressed RAM location when select rises.
- R7: If select rises after fewer than 16 data bits, only the received low-order bit positions are replaced. The other bits keep their old value.
- R8: Data bits beyond the sixteenth wrap round and overwrite the stored positions again, starting from D0.
- R9: A write completes only if `wr_permit` is high when select rises. Otherwise the RAM is unchanged.
- R10: If `nv_busy` is high when an instruction is decoded, the frame is ignored. No strobe is raised, no read data is driven and nothing is written.
- R11: After reset all strobes and `spi_sdo_en` are low, and every RAM word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Host select, active low, asynchronous |
| spi_sck | input | 1 | Host serial clock, asynchronous |
| spi_sdi | input | 1 | Host serial data in |
| spi_sdo | output | 1 | Serial read data |
| spi_sdo_en | output | 1 | Output enable for `spi_sdo` (low means high impedance) |
| wr_permit | input | 1 | Write-enable latch state from the nonvolatile controller |
| nv_busy | input | 1 | Nonvolatile operation in progress |
| cmd_we_clr | output | 1 | Strobe: clear write enable |
| cmd_store | output | 1 | Strobe: store RAM to nonvolatile array |
| cmd_autostore_en | output | 1 | Strobe: enable automatic store |
| cmd_we_set | output | 1 | Strobe: set write enable |
| cmd_recall | output | 1 | Strobe: recall nonvolatile array to RAM |

## Verification
Each command code is sent after a different number of leading zeros. This separates start-bit hunting from plain counting of clocks, and it confirms that every code reaches its own strobe. Writes are tried in three lengths: exactly 16 data bits, 4 bits and 20 bits. The results separate a full commit, a merge with the old contents and a wrap-round overwrite. Reads that run one bit past D15 show where the data starts and that it wraps. The same frames are then repeated with permit low or busy high, and frames are padded with trailing bits, so that each gating and ignore rule produces a different RAM or strobe outcome from the normal path.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_INSTR,
    ST_WDATA,
    ST_RDATA,
    ST_DONE
  } nvs_state_t;

  typedef struct packed {
    logic we_clr;
    logic store;
    logic as_en;
    logic we_set;
    logic recall;
  } nvs_cmd_t;

  localparam logic [2:0] OP_WE_CLR = 3'b000;
  localparam logic [2:0] OP_STORE  = 3'b001;
  localparam logic [2:0] OP_AS_EN  = 3'b010;
  localparam logic [2:0] OP_WRITE  = 3'b011;
  localparam logic [2:0] OP_WE_SET = 3'b100;
  localparam logic [2:0] OP_RECALL = 3'b101;

  function automatic nvs_cmd_t nvs_decode(input logic [2:0] op);
    nvs_cmd_t c;
    c = '0;
    case (op)
      OP_WE_CLR: c.we_clr = 1'b1;
      OP_STORE:  c.store  = 1'b1;
      OP_AS_EN:  c.as_en  = 1'b1;
      OP_WE_SET: c.we_set = 1'b1;
      OP_RECALL: c.recall = 1'b1;
      default:   c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/nvs_sync.sv
module nvs_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/nvs_ram.sv
module nvs_ram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              wr_permit,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DEPTH-1:0][DATA_W-1:0] mem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else if (wr_req && wr_permit) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];

  // R9: a closed permit leaves the whole array untouched
  p_no_permit_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_permit |=> $stable(mem_q));

  // R6: contents change only on a commit request
  p_write_only_on_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |=> $stable(mem_q));
endmodule

// File: rtl/nvs_frame.sv
module nvs_frame
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int INSTR_W = ADDR_W + 4,
  localparam int CNT_W = $clog2(DATA_W),
  localparam int BCNT_W = $clog2((DATA_W > INSTR_W) ? DATA_W : INSTR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              nv_busy,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_en,
  output nvs_cmd_t          cmd
);
  localparam logic [BCNT_W-1:0] RD_AT   = BCNT_W'(INSTR_W - 2);
  localparam logic [BCNT_W-1:0] DEC_AT  = BCNT_W'(INSTR_W - 1);
  localparam logic [BCNT_W-1:0] LAST_DB = BCNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0]  LAST_IX = CNT_W'(DATA_W - 1);

  nvs_state_t         state_q;
  logic [INSTR_W-1:0] ins_q;
  logic [INSTR_W-1:0] ins_nx;
  logic [BCNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  word_q;
  logic [CNT_W-1:0]   idx_q;
  logic               got_q;
  logic               sck_q;
  logic               sdo_q;
  logic               sdo_en_q;
  nvs_cmd_t           cmd_q;
  logic               rise;
  logic               fall;

  assign rise   = sck & ~sck_q;
  assign fall   = ~sck & sck_q;
  assign ins_nx = {ins_q[INSTR_W-2:0], sdi};

  assign rd_addr = (state_q == ST_RDATA) ? addr_q : ins_q[ADDR_W+1:2];
  assign wr_req  = cs_n && (state_q == ST_WDATA) && got_q;
  assign wr_addr = addr_q;
  assign wr_data = word_q;
  assign sdo     = sdo_q;
  assign sdo_en  = sdo_en_q;
  assign cmd     = cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_HUNT;
      ins_q    <= '0;
      cnt_q    <= '0;
      addr_q   <= '0;
      word_q   <= '0;
      idx_q    <= '0;
      got_q    <= 1'b0;
      sdo_q    <= 1'b0;
      sdo_en_q <= 1'b0;
      cmd_q    <= '0;
    end else begin
      cmd_q <= '0;
      if (cs_n) begin
        state_q  <= ST_HUNT;
        cnt_q    <= '0;
        got_q    <= 1'b0;
        sdo_q    <= 1'b0;
        sdo_en_q <= 1'b0;
      end else begin
        case (state_q)
          ST_HUNT: begin
            if (rise && sdi) begin
              ins_q   <= {{(INSTR_W-1){1'b0}}, 1'b1};
              cnt_q   <= BCNT_W'(1);
              state_q <= ST_INSTR;
            end
          end
          ST_INSTR: begin
            if (rise) begin
              ins_q <= ins_nx;
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == RD_AT && ins_nx[1:0] == 2'b11) begin
                if (nv_busy) state_q <= ST_DONE;
                else begin
                  state_q <= ST_RDATA;
                  addr_q  <= ins_nx[ADDR_W+1:2];
                  idx_q   <= '0;
                end
              end else if (cnt_q == DEC_AT) begin
                if (nv_busy) state_q <= ST_DONE;
                else if (ins_nx[2:0] == OP_WRITE) begin
                  state_q <= ST_WDATA;
                  addr_q  <= ins_nx[ADDR_W+2:3];
                  word_q  <= rd_data;
                  cnt_q   <= '0;
                  got_q   <= 1'b0;
                end else begin
                  cmd_q   <= nvs_decode(ins_nx[2:0]);
                  state_q <= ST_DONE;
                end
              end
            end
          end
          ST_WDATA: begin
            if (rise) begin
              word_q[cnt_q[CNT_W-1:0]] <= sdi;
              cnt_q <= (cnt_q == LAST_DB) ? '0 : cnt_q + 1'b1;
              got_q <= 1'b1;
            end
          end
          ST_RDATA: begin
            if (fall) begin
              sdo_q    <= rd_data[idx_q];
              sdo_en_q <= 1'b1;
              idx_q    <= (idx_q == LAST_IX) ? '0 : idx_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3: never two strobes together
  p_onehot_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_q));

  // R3: a strobe lasts a single cycle
  p_cmd_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_q) |=> !(|cmd_q));

  // R10: no strobe follows a decode made while busy
  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_q) |-> !$past(nv_busy));

  // R5: releasing select tri-states the output
  p_hiz_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !sdo_en_q);

  // R4: driven read data moves only on falling serial edges
  p_sdo_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_en_q && !$stable(sdo_q)) |-> $past(fall));
endmodule

// File: rtl/nvsram_serial_if.sv
module nvsram_serial_if
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_sdi,
  output logic spi_sdo,
  output logic spi_sdo_en,
  input  logic wr_permit,
  input  logic nv_busy,
  output logic cmd_we_clr,
  output logic cmd_store,
  output logic cmd_autostore_en,
  output logic cmd_we_set,
  output logic cmd_recall
);
  logic [2:0]        pins_s;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              wr_req;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  nvs_cmd_t          cmd;

  nvs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_cs_n, spi_sck, spi_sdi}),
    .q(pins_s)
  );

  nvs_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .cs_n(pins_s[2]), .sck(pins_s[1]), .sdi(pins_s[0]),
    .nv_busy(nv_busy),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo(spi_sdo), .sdo_en(spi_sdo_en),
    .cmd(cmd)
  );

  nvs_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .wr_req(wr_req), .wr_permit(wr_permit),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign cmd_we_clr       = cmd.we_clr;
  assign cmd_store        = cmd.store;
  assign cmd_autostore_en = cmd.as_en;
  assign cmd_we_set       = cmd.we_set;
  assign cmd_recall       = cmd.recall;
endmodule

// File: tb/nvsram_serial_if_test.sv
`timescale 1ns/1ps
module nvsram_serial_if_test;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic permit = 1'b0, busy = 1'b0;
  logic sdo, sdo_en, s_clr, s_sto, s_ase, s_set, s_rcl;

  always #2.5 clk = ~clk;

  nvsram_serial_if uut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_sdi(sdi),
    .spi_sdo(sdo), .spi_sdo_en(sdo_en), .wr_permit(permit), .nv_busy(busy),
    .cmd_we_clr(s_clr), .cmd_store(s_sto), .cmd_autostore_en(s_ase),
    .cmd_we_set(s_set), .cmd_recall(s_rcl)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit h1c = 1, h2c = 1, h3c = 1, h1k = 0, h2k = 0, h3k = 0, h1d = 0, h2d = 0, h3d = 0;
  int m_state = 0;   // 0 hunt, 1 instr, 2 write data, 3 read data, 4 done
  int m_cnt = 0, m_idx = 0, m_addr = 0;
  bit [7:0] m_ins = 0;
  bit [15:0] m_word = 0;
  bit m_got = 0, m_sdo = 0, m_en = 0;
  bit [4:0] m_str = 0;     // {clr, store, autostore, set, recall}
  bit [15:0] m_mem [16];

  always @(posedge clk) begin
    bit c, r, f, d;
    if (!rst_n) begin
      h1c = 1; h2c = 1; h3c = 1; h1k = 0; h2k = 0; h3k = 0; h1d = 0; h2d = 0; h3d = 0;
      m_state = 0; m_cnt = 0; m_got = 0; m_sdo = 0; m_en = 0; m_str = 0;
      foreach (m_mem[i]) m_mem[i] = 16'h0;
    end else begin
      c = h2c; d = h2d;
      r = h2k && !h3k;
      f = !h2k && h3k;
      m_str = 0;
      if (c) begin
        if (m_state == 2 && m_got && permit) m_mem[m_addr] = m_word;
        m_state = 0; m_cnt = 0; m_got = 0; m_en = 0; m_sdo = 0;
      end else if (m_state == 0) begin
        if (r && d) begin m_ins = 8'h01; m_cnt = 1; m_state = 1; end
      end else if (m_state == 1) begin
        if (r) begin
          m_ins = {m_ins[6:0], d};
          m_cnt++;
          if (m_cnt == 7 && m_ins[1:0] == 2'b11) begin
            if (busy) m_state = 4;
            else begin m_state = 3; m_addr = int'(m_ins[5:2]); m_idx = 0; end
          end else if (m_cnt == 8) begin
            if (busy) m_state = 4;
            else if (m_ins[2:0] == 3'b011) begin
              m_state = 2; m_addr = int'(m_ins[6:3]); m_word = m_mem[m_addr];
              m_cnt = 0; m_got = 0;
            end else begin
              case (m_ins[2:0])
                3'b000: m_str = 5'b10000;
                3'b001: m_str = 5'b01000;
                3'b010: m_str = 5'b00100;
                3'b100: m_str = 5'b00010;
                3'b101: m_str = 5'b00001;
                default: m_str = 0;
              endcase
              m_state = 4;
            end
          end
        end
      end else if (m_state == 2) begin
        if (r) begin m_word[m_cnt] = d; m_cnt = (m_cnt + 1) % 16; m_got = 1; end
      end else if (m_state == 3) begin
        if (f) begin m_sdo = m_mem[m_addr][m_idx]; m_en = 1; m_idx = (m_idx + 1) % 16; end
      end
      h3c = h2c; h2c = h1c; h1c = cs_n;
      h3k = h2k; h2k = h1k; h1k = sck;
      h3d = h2d; h2d = h1d; h1d = sdi;
    end
  end

  int n_clr = 0, n_sto = 0, n_ase = 0, n_set = 0, n_rcl = 0, n_en = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(sdo_en == m_en, "R5 model sdo_en", sdo_en, m_en);
      if (m_en) check(sdo == m_sdo, "R4 model sdo", sdo, m_sdo);
      check({s_clr, s_sto, s_ase, s_set, s_rcl} == m_str, "R2 model strobes",
            {s_clr, s_sto, s_ase, s_set, s_rcl}, m_str);
      n_clr += s_clr; n_sto += s_sto; n_ase += s_ase; n_set += s_set; n_rcl += s_rcl;
      n_en  += sdo_en;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic clr_counts();
    n_clr = 0; n_sto = 0; n_ase = 0; n_set = 0; n_rcl = 0; n_en = 0;
  endtask

  task automatic bit_tx(input bit b, output bit seen);
    @(negedge clk); sck = 0; sdi = b;
    repeat (HALF) @(negedge clk);
    seen = sdo;
    sck = 1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic f_begin();
    @(negedge clk); cs_n = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic f_end();
    @(negedge clk); sck = 0;
    repeat (4) @(negedge clk);
    cs_n = 1;
    repeat (10) @(negedge clk);
  endtask

  task automatic send_bits(input bit [7:0] v, input int n);
    bit s;
    for (int i = n - 1; i >= 0; i--) bit_tx(v[i], s);
  endtask

  task automatic zeros(input int n);
    bit s;
    for (int i = 0; i < n; i++) bit_tx(1'b0, s);
  endtask

  task automatic do_cmd(input bit [2:0] op, input bit [3:0] a, input int lz, input int extra);
    f_begin(); zeros(lz); send_bits({1'b1, a, op}, 8);
    if (extra > 0) send_bits(8'b1000_0001, extra);
    f_end();
  endtask

  task automatic do_write(input bit [3:0] a, input bit [31:0] v, input int n, input int lz);
    bit s;
    f_begin(); zeros(lz); send_bits({1'b1, a, 3'b011}, 8);
    for (int i = 0; i < n; i++) bit_tx(v[i], s);
    f_end();
  endtask

  task automatic do_read(input bit [3:0] a, input int n, output bit [31:0] got);
    bit s;
    got = 0;
    f_begin(); send_bits({1'b1, a, 2'b11}, 7);
    for (int i = 0; i < n; i++) begin bit_tx(1'b0, s); got[i] = s; end
    f_end();
  endtask

  // ---------------- tests ----------------
  initial begin
    bit [31:0] rv;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    check(sdo_en == 0, "R11 reset sdo_en", sdo_en, 0);
    check({s_clr, s_sto, s_ase, s_set, s_rcl} == 0, "R11 reset strobes",
          {s_clr, s_sto, s_ase, s_set, s_rcl}, 0);
    do_read(4'd3, 16, rv);
    check(rv[15:0] == 16'h0, "R11 reset RAM word", rv[15:0], 0);

    // R1 R2 R3: each code after its own count of leading zeros
    clr_counts(); do_cmd(3'b000, 4'h9, 0, 0);
    check(n_clr == 1 && n_sto + n_ase + n_set + n_rcl == 0, "R2 clear-we strobe", n_clr, 1);
    clr_counts(); do_cmd(3'b001, 4'h3, 3, 0);
    check(n_sto == 1 && n_clr + n_ase + n_set + n_rcl == 0, "R1 store after zeros", n_sto, 1);
    clr_counts(); do_cmd(3'b010, 4'hF, 5, 0);
    check(n_ase == 1, "R2 autostore strobe", n_ase, 1);
    clr_counts(); do_cmd(3'b100, 4'h0, 1, 0);
    check(n_set == 1, "R3 set-we single pulse", n_set, 1);
    clr_counts(); do_cmd(3'b101, 4'h6, 7, 0);
    check(n_rcl == 1, "R2 recall strobe", n_rcl, 1);

    // R6 full write, R4 read with wrap
    permit = 1;
    do_write(4'd5, 32'h0000_A5C3, 16, 2);
    do_read(4'd5, 17, rv);
    check(rv[15:0] == 16'hA5C3, "R6 full write readback", rv[15:0], 16'hA5C3);
    check(rv[16] == 1'b1, "R4 wrap to D0", rv[16], 1);

    // R7 partial write
    do_write(4'd5, 32'h0000_0006, 4, 0);
    do_read(4'd5, 16, rv);
    check(rv[15:0] == 16'hA5C6, "R7 partial merge", rv[15:0], 16'hA5C6);

    // R8 over-length write
    do_write(4'd9, 32'h000B_1234, 20, 0);
    do_read(4'd9, 16, rv);
    check(rv[15:0] == 16'h123B, "R8 overwrite wrap", rv[15:0], 16'h123B);

    // R9 no permit
    permit = 0;
    do_write(4'd5, 32'h0000_FFFF, 16, 0);
    do_read(4'd5, 16, rv);
    check(rv[15:0] == 16'hA5C6, "R9 write blocked", rv[15:0], 16'hA5C6);
    permit = 1;

    // R10 busy
    busy = 1;
    clr_counts(); do_cmd(3'b001, 4'h0, 0, 0);
    check(n_sto == 0, "R10 busy store ignored", n_sto, 0);
    do_write(4'd9, 32'h0000_0000, 16, 0);
    clr_counts(); do_read(4'd9, 16, rv);
    check(n_en == 0, "R10 busy read not driven", n_en, 0);
    busy = 0;
    do_read(4'd9, 16, rv);
    check(rv[15:0] == 16'h123B, "R10 busy write ignored", rv[15:0], 16'h123B);

    // R5 trailing bits after a command are ignored; output idle after frames
    clr_counts(); do_cmd(3'b100, 4'h2, 0, 8);
    check(n_set == 1 && n_rcl == 0 && n_sto == 0, "R5 trailing bits ignored", n_rcl, 0);
    check(sdo_en == 0, "R5 idle after frame", sdo_en, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule